// File: doc/BRIEF.md
# Stretch-Safe SCL Clock Generator

This block produces the serial clock of a two-wire bus controller at standard speed from a fast system clock. It only ever pulls the clock line low or lets it go. It watches the real line level through an internal synchroniser and waits for as long as a target holds the clock low. The block has one rule that matters most: the high phase after a release is timed from the moment the line is actually seen high. Because of this, a target letting go of the clock at any phase can never produce a short high pulse. A byte engine next to the block uses the one-cycle `fall_tick` and `rise_tick` strobes to shift data and sample the data line.

The controller is a four-state machine with states IDLE, DRIVE_LO, WAIT_HI and HOLD_HI. The transitions are:
- **IDLE → DRIVE_LO**, called *start*: `enable` is high. The line is pulled low and `fall_tick` pulses.
- **DRIVE_LO → WAIT_HI**, called *release*: the low count has run out. The output enable drops.
- **WAIT_HI → HOLD_HI**, called *seen-high*: the synchronised line reads high. `rise_tick` pulses and the high count starts at zero.
- **HOLD_HI → DRIVE_LO**, called *next-bit*: the high count has run out.
- **any → IDLE**, called *abort*: `enable` is low.

The counter is frozen at zero in WAIT_HI, so a stretch of any length resumes from a clean count. With the default 16 MHz system clock, a half setting of 80 gives an 80-cycle low phase. The high interval is 83 cycles, because it includes the two-stage synchroniser and the state register. No high interval is shorter than the half setting.

Top module: `scl_pacer`

## Requirements
- R1: While `rst_n` is low, or while `enable` is low, `scl_oe` is 0 and neither tick pulses. After `enable` is seen low at a clock edge, `scl_oe` is 0 from that edge onward.
- R2: With no target stretching, `scl_oe` is 1 (line pulled low) for exactly H consecutive cycles in each period. H is the effective half setting. `fall_tick` pulses for one cycle, in the first of those cycles.
- R3: After `scl_oe` drops, while the line still reads low, `scl_oe` stays 0 and neither tick pulses. A stretch of N cycles past the end of the driven low phase gives a line low interval of H+N cycles.
- R4: Every high interval of the line lasts exactly H+3 cycles: 2 synchroniser stages, 1 state cycle, and H counted cycles. This holds with no stretch and for every stretch length, including lengths that are whole multiples of the nominal period.
- R5: `rise_tick` pulses exactly once per high interval, in the fourth cycle of that interval. It never pulses in the same cycle as `fall_tick`, and never while `scl_oe` is 1.
- R6: After `enable` is dropped and raised again, the first low phase is a full H cycles, because both phase counts restart from zero.
- R7: The effective half setting H is `half_div` raised to a minimum of 4. Settings of 0 to 3 give a 4-cycle low phase and a 7-cycle high interval.
- R8: A change to `half_div` takes effect at the start of the next phase. A phase already running keeps the length it started with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the clock; low aborts to IDLE and releases the line |
| half_div | input | CNT_W (8) | Cycles per low phase and per counted high phase (minimum 4) |
| scl_in | input | 1 | Raw clock line level, asynchronous |
| scl_oe | output | 1 | 1 = pull the clock line low, 0 = release it |
| rise_tick | output | 1 | One-cycle strobe when the released line is first seen high |
| fall_tick | output | 1 | One-cycle strobe in the first cycle the line is pulled low |

## Verification
The bench models the bus as a wired-AND of `scl_oe`, a target hold signal and an instant pull-up. It measures every low and high interval on the modelled line.

The clock runs free with no stretching. Those intervals show the base low and high widths and the tick placement.

The target then stretches by 1 to 326 cycles. Some of these lengths land exactly on multiples of the nominal period. The rest land just before or after those multiples. This shows that the high interval does not depend on when the release happens, which is the failure this block exists to prevent.

Other scenarios abort mid-phase, set the divider below its minimum, and change the divider in the middle of a phase. These tell apart counter clearing, clamping and per-phase latching of the limit.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_DRIVE_LO = 2'd1,
        ST_WAIT_HI  = 2'd2,
        ST_HOLD_HI  = 2'd3
    } pace_state_t;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= 1'b1;
                else        chain_q[0] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[i] <= 1'b1;
                else        chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W    = 8,
    parameter int MIN_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] half_set,
    output logic             done
);

    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_HALF);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] eff_lim;

    // Clamp the requested half setting to the minimum.
    assign eff_lim = (half_set < MIN_V) ? MIN_V : half_set;
    assign done    = run && (count_q == lim_q - CNT_W'(1));

    // The limit is captured while idle and at the end of each phase,
    // so a running phase never sees a new setting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             lim_q <= MIN_V;
        else if (!run || done)  lim_q <= eff_lim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (!run)   count_q <= '0;
        else if (done)   count_q <= '0;
        else             count_q <= count_q + CNT_W'(1);
    end

    // R8
    count_below_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count_q < lim_q));

    // R7
    limit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lim_q >= MIN_V);

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_pacer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic line_hi,
    input  logic phase_done,
    output logic run,
    output logic scl_oe,
    output logic rise_tick,
    output logic fall_tick
);

    pace_state_t state_q;
    pace_state_t nxt;

    // Next-state logic.
    always_comb begin
        nxt = state_q;
        if (!enable) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     nxt = ST_DRIVE_LO;
                ST_DRIVE_LO: if (phase_done) nxt = ST_WAIT_HI;
                ST_WAIT_HI:  if (line_hi)    nxt = ST_HOLD_HI;
                ST_HOLD_HI:  if (phase_done) nxt = ST_DRIVE_LO;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_oe    <= 1'b0;
            fall_tick <= 1'b0;
            rise_tick <= 1'b0;
        end else begin
            scl_oe    <= (nxt == ST_DRIVE_LO);
            fall_tick <= (nxt == ST_DRIVE_LO) && (state_q != ST_DRIVE_LO);
            rise_tick <= (nxt == ST_HOLD_HI)  && (state_q != ST_HOLD_HI);
        end
    end

    // The phase counter advances only in the two timed states.
    assign run = enable && ((state_q == ST_DRIVE_LO) || (state_q == ST_HOLD_HI));

    // R1
    oe_off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !scl_oe);

    // R3
    no_tick_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HI && !line_hi) |=> (!rise_tick && !fall_tick && !scl_oe));

    // R2
    fall_with_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> fall_tick);

    // R5
    rise_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> ($past(line_hi) && !scl_oe));

    // R5
    ticks_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise_tick, fall_tick}));

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer #(
    parameter int CNT_W       = 8,
    parameter int MIN_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] half_div,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic line_hi;
    logic run;
    logic phase_done;

    scl_sync #(
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (scl_in),
        .d_sync  (line_hi)
    );

    phase_timer #(
        .CNT_W    (CNT_W),
        .MIN_HALF (MIN_HALF)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_set (half_div),
        .done     (phase_done)
    );

    scl_phase_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .line_hi    (line_hi),
        .phase_done (phase_done),
        .run        (run),
        .scl_oe     (scl_oe),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick)
    );

endmodule

// File: tb/sim_scl_pacer.sv
`timescale 1ns/1ps
module sim_scl_pacer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] half_div = 8'd80;
    logic       tgt_hold = 1'b0;
    logic       scl_oe, rise_tick, fall_tick;
    logic       scl_line;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Wired-AND bus with an instant pull-up.
    assign scl_line = !(scl_oe || tgt_hold);

    always #4 clk = ~clk;

    scl_pacer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .half_div  (half_div),
        .scl_in    (scl_line),
        .scl_oe    (scl_oe),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    // Line monitor, sampled at the falling clock edge.
    int  hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, rise_pos = 0;
    int  rise_cnt = 0, fall_cnt = 0, line_rises = 0, line_falls = 0, wait_tick_bad = 0;
    bit  prev_line = 1'b1;

    always @(negedge clk) begin
        if (scl_line) begin
            if (!prev_line) begin
                last_lo = lo_run;
                hi_run = 0;
                line_rises++;
            end
            hi_run++;
            if (rise_tick) rise_pos = hi_run;
        end else begin
            if (prev_line) begin
                last_hi = hi_run;
                lo_run = 0;
                line_falls++;
            end
            lo_run++;
        end
        prev_line = scl_line;
        if (rise_tick) rise_cnt++;
        if (fall_tick) fall_cnt++;
        if ((rise_tick || fall_tick) && !scl_oe && !scl_line) wait_tick_bad++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_line_rise();
        int c = line_rises;
        do @(posedge clk); while (line_rises == c);
    endtask

    task automatic wait_line_fall();
        int c = line_falls;
        do @(posedge clk); while (line_falls == c);
    endtask

    task automatic do_enable(input bit v);
        @(posedge clk); #2 enable = v;
    endtask

    // Reset and disabled state.
    task automatic test_reset();
        int t0;
        @(negedge clk); #1;
        chk("R1 oe in reset", scl_oe, 0);
        chk("R1 ticks in reset", rise_tick | fall_tick, 0);
        @(posedge clk); #2 rst_n = 1'b1;
        t0 = rise_cnt + fall_cnt;
        repeat (20) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 oe while disabled", scl_oe, 0);
        chk("R1 ticks while disabled", rise_cnt + fall_cnt - t0, 0);
    endtask

    // Free-running clock, no stretching.
    task automatic test_free_run();
        int r0, f0;
        do_enable(1'b1);
        wait_line_fall();
        wait_line_fall();
        r0 = rise_cnt; f0 = fall_cnt;
        repeat (5) wait_line_fall();
        chk("R2 low width", last_lo, 80);
        chk("R4 high width", last_hi, 83);
        chk("R5 rise position", rise_pos, 4);
        chk("R2 one fall tick per period", fall_cnt - f0, 5);
        chk("R5 one rise tick per period", rise_cnt - r0, 5);
    endtask

    // Target holds the line N cycles past the driven low phase.
    task automatic test_stretch(input int n);
        int c;
        c = fall_cnt;
        do @(posedge clk); while (fall_cnt == c);
        #2 tgt_hold = 1'b1;
        do @(negedge clk); while (scl_oe);
        repeat (n) @(posedge clk);
        #2 tgt_hold = 1'b0;
        wait_line_fall();
        chk($sformatf("R3 low width stretch %0d", n), last_lo, 80 + n);
        chk($sformatf("R4 high width stretch %0d", n), last_hi, 83);
        chk($sformatf("R5 rise position stretch %0d", n), rise_pos, 4);
        chk($sformatf("R3 no tick while held %0d", n), wait_tick_bad, 0);
    endtask

    // Abort in the middle of a low phase and in a high phase.
    task automatic test_disable();
        int c, t0;
        c = fall_cnt;
        do @(posedge clk); while (fall_cnt == c);
        repeat (20) @(posedge clk);
        #2 enable = 1'b0;
        @(posedge clk);
        @(negedge clk); #1;
        chk("R6 oe off after abort", scl_oe, 0);
        t0 = rise_cnt + fall_cnt;
        repeat (6) @(posedge clk);
        chk("R1 no ticks after abort", rise_cnt + fall_cnt - t0, 0);
        #2 enable = 1'b1;
        wait_line_rise();
        chk("R6 full low after restart", last_lo, 80);
        c = rise_cnt;
        do @(posedge clk); while (rise_cnt == c);
        repeat (30) @(posedge clk);
        #2 enable = 1'b0;
        repeat (4) @(posedge clk);
        #2 enable = 1'b1;
        wait_line_rise();
        chk("R6 full low after high abort", last_lo, 80);
        wait_line_fall();
        chk("R6 high after restart", last_hi, 83);
    endtask

    // Settings below the minimum.
    task automatic test_clamp(input logic [7:0] h);
        do_enable(1'b0);
        repeat (3) @(posedge clk);
        #2 half_div = h;
        do_enable(1'b1);
        repeat (3) wait_line_fall();
        chk($sformatf("R7 clamped low for %0d", h), last_lo, 4);
        chk($sformatf("R7 clamped high for %0d", h), last_hi, 7);
    endtask

    // Setting changed during a low phase.
    task automatic test_midphase();
        int c;
        do_enable(1'b0);
        repeat (3) @(posedge clk);
        #2 half_div = 8'd80;
        do_enable(1'b1);
        wait_line_fall();
        c = fall_cnt;
        do @(posedge clk); while (fall_cnt == c);
        repeat (10) @(posedge clk);
        #2 half_div = 8'd40;
        wait_line_rise();
        chk("R8 running low keeps old length", last_lo, 80);
        wait_line_fall();
        chk("R8 next high uses new length", last_hi, 43);
        wait_line_rise();
        chk("R8 next low uses new length", last_lo, 40);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_free_run();
        foreach (stretch_set[i]) test_stretch(stretch_set[i]);
        test_disable();
        test_clamp(8'd0);
        test_clamp(8'd3);
        test_midphase();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    int stretch_set[10] = '{1, 2, 3, 7, 80, 159, 160, 161, 163, 326};

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule